// File: doc/BRIEF.md
# Push-Pull Two-Wire Serial Transmitter

This block sends write-only frames on a two-wire serial link whose clock and data lines are both driven push-pull by the master. A frame starts when a one-cycle start request arrives while the block is idle. The frame is built from a 7-bit target address, a direction/command bit and a programmable count of data bytes. The data bytes come from a local buffer: the block presents a byte index and reads the byte on the same cycle.

Each group of eight bits is followed by a ninth clock. During that clock the transmitter holds data HIGH and never looks at the line, so there is no acknowledge, arbitration or clock stretching. The bit period and the lag from a falling clock edge to a data change are set in system clocks. Both values, together with the address, direction and byte count, are captured when the frame starts. The clock output can be driven straight to a pad. Busy and done tell the surrounding logic when a frame is in flight and when it has ended.

Top module: `pp2w_tx`

## Requirements
- R1: Out of reset and whenever no frame is in flight, the clock and data outputs are both HIGH, busy is LOW and done is LOW.
- R2: A frame opens with data falling while the clock is HIGH. This happens on the first busy cycle, and the clock then stays HIGH for floor(P/2) cycles, where P is the effective period.
- R3: The bits presented at clock rising edges are, in order: address bits 6 down to 0, then the direction bit, then a ninth bit, then each data byte MSB first followed by its own ninth bit. Data byte k is the byte read while byte_idx_o equals k, for k running from 0 up to nbytes-1.
- R4: The data line is HIGH during every ninth clock.
- R5: Every clock LOW phase inside a frame lasts P - floor(P/2) cycles. Every HIGH phase that ends in a falling edge lasts floor(P/2) cycles.
- R6: The effective period P is the period input captured at start. A value of 0 selects the default of 32, and values 1 to 3 are raised to 4.
- R7: The data line never changes while the clock is rising. Inside a frame, every data change other than those of START and STOP happens with the clock LOW, exactly D cycles after the last clock fall, where D = min(delay, P - floor(P/2) - 1).
- R8: After the last ninth clock there is one more bit slot with data LOW. Data then rises while the clock stays HIGH, which is the STOP condition, and both lines then remain HIGH.
- R9: Busy is HIGH for exactly 2*floor(P/2) + (9*(nbytes+1)+1)*P cycles. Done is a single-cycle pulse in the first cycle after busy falls.
- R10: A start request during a frame is ignored. Changes on the address, direction, count, period or delay inputs during a frame do not alter that frame.
- R11: A byte count of 0 sends a frame that holds only the address byte and its ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a frame; honoured only when idle |
| addr_i | input | 7 | Target address, captured at start |
| dir_i | input | 1 | Direction/command bit sent after the address |
| nbytes_i | input | NB_W (4) | Number of data bytes in the frame |
| period_i | input | PER_W (8) | Bit period in system clocks (0 selects the default) |
| delay_i | input | DLY_W (8) | Clock-fall to data-change lag in system clocks |
| byte_idx_o | output | NB_W (4) | Index of the next data byte wanted from the buffer |
| byte_i | input | 8 | Buffer byte at byte_idx_o, read on the same cycle |
| scl_o | output | 1 | Serial clock line, push-pull |
| sda_o | output | 1 | Serial data line, push-pull |
| busy_o | output | 1 | HIGH while a frame is in flight |
| done_o | output | 1 | One-cycle pulse after a frame ends |

## Verification
The bench sweeps odd, even, default and clamped periods, because a design that splits an odd period the wrong way, or that omits the 0 and below-4 substitutions, shows LOW or HIGH runs of the wrong length. It uses delays of zero, within range and beyond the LOW phase. A missing clamp would then move data into the HIGH phase, and an off-by-one in the lag compare would show up as a wrong measured lag. A frame with no data bytes and a frame with three bytes check the end-of-frame decision: a design with a wrong byte count would send an extra or missing byte, a wrong ninth bit or a misplaced STOP slot. A second start request and changed inputs during a running frame would, in a design that does not capture its settings, corrupt the bits or lengthen the frame.

// File: rtl/pp2w_pkg.sv
package pp2w_pkg;

    // frame sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_SLOT,
        ST_STOPL,
        ST_STOPH
    } pp2w_st_e;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int BIT_W  = 4;   // bit index 0..8 within a slot group

endpackage

// File: rtl/pp2w_timing.sv
// Derives the effective phase lengths from the captured period and delay.
module pp2w_timing #(
    parameter int PER_W      = 8,
    parameter int DLY_W      = 8,
    parameter int DEF_PERIOD = 32,
    parameter int MIN_PERIOD = 4
) (
    input  logic [PER_W-1:0] per_raw,
    input  logic [DLY_W-1:0] dly_raw,
    output logic [PER_W-1:0] per_last,
    output logic [PER_W-1:0] hi_last,
    output logic [PER_W-1:0] lo_len,
    output logic [PER_W-1:0] dly_eff
);
    localparam int CW = (PER_W > DLY_W) ? PER_W : DLY_W;

    logic [PER_W-1:0] per_eff;
    logic [PER_W-1:0] hi_len;

    always_comb begin
        if (per_raw == '0) begin
            per_eff = PER_W'(DEF_PERIOD);
        end else if (per_raw < PER_W'(MIN_PERIOD)) begin
            per_eff = PER_W'(MIN_PERIOD);
        end else begin
            per_eff = per_raw;
        end
        hi_len   = per_eff >> 1;
        lo_len   = per_eff - hi_len;
        per_last = per_eff - PER_W'(1);
        hi_last  = hi_len - PER_W'(1);
        if (CW'(dly_raw) >= CW'(lo_len)) begin
            dly_eff = lo_len - PER_W'(1);
        end else begin
            dly_eff = PER_W'(dly_raw);
        end
    end
endmodule

// File: rtl/pp2w_slot_ctr.sv
// Phase counter: counts 0..last, then wraps; held at zero while cleared.
module pp2w_slot_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] last,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cnt_nx_o,
    output logic         wrap_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        wrap_o = !clear && (cnt_q == last);
        if (clear || wrap_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o    = cnt_q;
    assign cnt_nx_o = cnt_d;
endmodule

// File: rtl/pp2w_tx.sv
module pp2w_tx
    import pp2w_pkg::*;
#(
    parameter int PER_W      = 8,
    parameter int DLY_W      = 8,
    parameter int NB_W       = 4,
    parameter int DEF_PERIOD = 32,
    parameter int MIN_PERIOD = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              dir_i,
    input  logic [NB_W-1:0]   nbytes_i,
    input  logic [PER_W-1:0]  period_i,
    input  logic [DLY_W-1:0]  delay_i,
    output logic [NB_W-1:0]   byte_idx_o,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              scl_o,
    output logic              sda_o,
    output logic              busy_o,
    output logic              done_o
);
    typedef struct packed {
        pp2w_st_e          st;
        logic [BIT_W-1:0]  bit_i;
        logic [NB_W-1:0]   nb;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] hdr;
        logic [NB_W-1:0]   nby;
        logic [PER_W-1:0]  per;
        logic [DLY_W-1:0]  dly;
        logic              scl;
        logic              sda;
        logic              busy;
        logic              done;
    } tx_state_t;

    tx_state_t r_d, r_q;

    logic [PER_W-1:0] per_last, hi_last, lo_len, dly_eff;
    logic [PER_W-1:0] cnt_q, cnt_nx, ctr_last;
    logic             ctr_clear, wrap;
    logic             ninth_w;

    pp2w_timing #(
        .PER_W      (PER_W),
        .DLY_W      (DLY_W),
        .DEF_PERIOD (DEF_PERIOD),
        .MIN_PERIOD (MIN_PERIOD)
    ) u_timing (
        .per_raw  (r_q.per),
        .dly_raw  (r_q.dly),
        .per_last (per_last),
        .hi_last  (hi_last),
        .lo_len   (lo_len),
        .dly_eff  (dly_eff)
    );

    assign ctr_clear = (r_q.st == ST_IDLE);
    assign ctr_last  = ((r_q.st == ST_START) || (r_q.st == ST_STOPH)) ? hi_last : per_last;

    pp2w_slot_ctr #(
        .W (PER_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (ctr_clear),
        .last     (ctr_last),
        .cnt_o    (cnt_q),
        .cnt_nx_o (cnt_nx),
        .wrap_o   (wrap)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;

        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_START;
                    r_d.hdr  = {addr_i, dir_i};
                    r_d.nby  = nbytes_i;
                    r_d.per  = period_i;
                    r_d.dly  = delay_i;
                    r_d.busy = 1'b1;
                    r_d.sda  = 1'b0;          // START: data falls, clock high
                end
            end
            ST_START: begin
                if (wrap) begin
                    r_d.st    = ST_SLOT;
                    r_d.sh    = r_q.hdr;
                    r_d.bit_i = '0;
                    r_d.nb    = '0;
                end
            end
            ST_SLOT: begin
                if (wrap) begin
                    if (r_q.bit_i == BIT_W'(8)) begin
                        if (r_q.nb == r_q.nby) begin
                            r_d.st = ST_STOPL;
                        end else begin
                            r_d.sh    = byte_i;
                            r_d.bit_i = '0;
                            r_d.nb    = r_q.nb + NB_W'(1);
                        end
                    end else if (r_q.bit_i == BIT_W'(7)) begin
                        r_d.bit_i = BIT_W'(8);
                    end else begin
                        r_d.sh    = {r_q.sh[BYTE_W-2:0], 1'b0};
                        r_d.bit_i = r_q.bit_i + BIT_W'(1);
                    end
                end
            end
            ST_STOPL: begin
                if (wrap) begin
                    r_d.st  = ST_STOPH;
                    r_d.sda = 1'b1;           // STOP: data rises, clock high
                end
            end
            ST_STOPH: begin
                if (wrap) begin
                    r_d.st   = ST_IDLE;
                    r_d.busy = 1'b0;
                    r_d.done = 1'b1;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase

        // data moves only at the programmed lag inside a bit slot
        if (((r_d.st == ST_SLOT) || (r_d.st == ST_STOPL)) && (cnt_nx == dly_eff)) begin
            if (r_d.st == ST_STOPL) begin
                r_d.sda = 1'b0;
            end else if (r_d.bit_i == BIT_W'(8)) begin
                r_d.sda = 1'b1;
            end else begin
                r_d.sda = r_d.sh[BYTE_W-1];
            end
        end

        // clock low for the first part of a slot, high for the rest
        if ((r_d.st == ST_SLOT) || (r_d.st == ST_STOPL)) begin
            r_d.scl = (cnt_nx >= lo_len);
        end else begin
            r_d.scl = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.scl   <= 1'b1;
            r_q.sda   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign byte_idx_o = r_q.nb;
    assign scl_o      = r_q.scl;
    assign sda_o      = r_q.sda;
    assign busy_o     = r_q.busy;
    assign done_o     = r_q.done;
    assign ninth_w    = (r_q.st == ST_SLOT) && (r_q.bit_i == BIT_W'(8));

endmodule

// File: rtl/pp2w_tx_chk.sv
module pp2w_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_o,
    input logic sda_o,
    input logic busy_o,
    input logic done_o,
    input logic ninth
);
    // R1: lines rest high outside a frame
    a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (scl_o && sda_o));

    // R9: done lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: done follows the fall of busy
    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R7: data stable across every rising clock
    a_r7_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_o) |-> $stable(sda_o));

    // R4: ninth clock carries a high data line
    a_r4_ninth_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ninth && scl_o) |-> sda_o);

    // R2: a falling data line under a high clock only opens a frame
    a_r2_start_only: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_o) && scl_o && $past(scl_o)) |-> $rose(busy_o));
endmodule

bind pp2w_tx pp2w_tx_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_o  (scl_o),
    .sda_o  (sda_o),
    .busy_o (busy_o),
    .done_o (done_o),
    .ninth  (ninth_w)
);

// File: tb/pp2w_tx_test.sv
module pp2w_tx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [6:0] addr_i = '0;
    logic       dir_i = 1'b0;
    logic [3:0] nbytes_i = '0;
    logic [7:0] period_i = '0;
    logic [7:0] delay_i = '0;
    logic [3:0] byte_idx_o;
    logic [7:0] byte_i;
    logic       scl_o, sda_o, busy_o, done_o;

    always #10 clk = ~clk;   // 50 MHz

    pp2w_tx uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .dir_i(dir_i),
        .nbytes_i(nbytes_i), .period_i(period_i), .delay_i(delay_i),
        .byte_idx_o(byte_idx_o), .byte_i(byte_i),
        .scl_o(scl_o), .sda_o(sda_o), .busy_o(busy_o), .done_o(done_o)
    );

    // buffer model
    logic [7:0] seed_r = '0;
    function automatic logic [7:0] buf_byte(input logic [7:0] s, input int idx);
        logic [7:0] t;
        t = idx[7:0] * 8'h3B + 8'h11;
        return s ^ t;
    endfunction
    assign byte_i = buf_byte(seed_r, int'(byte_idx_o));

    // expectations for the current frame
    int         exp_p, exp_lo, exp_hi, exp_dly, exp_n;
    logic [6:0] exp_addr;
    logic       exp_dir;
    logic [7:0] exp_seed;

    int n_total = 0;
    int n_fail  = 0;

    task automatic check(input string req, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // line monitor
    int   cyc = 0;
    logic p_scl = 1'b1, p_sda = 1'b1, p_busy = 1'b0;
    int   hrun, lrun, t_fall;
    int   m_nrise, m_bad_lo, m_bad_hi, m_bad_lag, m_starts, m_stops, m_blen;
    int   m_ndone = 0, m_bad_done = 0;
    logic m_bits [0:255];

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (busy_o && !p_busy) begin
                m_nrise = 0; m_bad_lo = 0; m_bad_hi = 0; m_bad_lag = 0;
                m_starts = 0; m_stops = 0; m_blen = 0; hrun = 0; lrun = 0; t_fall = cyc;
            end
            if (busy_o) begin
                m_blen++;
                if (scl_o && !p_scl) begin
                    if (lrun != exp_lo) m_bad_lo++;
                    hrun = 1;
                    if (m_nrise < 256) m_bits[m_nrise] = sda_o;
                    m_nrise++;
                end else if (scl_o) begin
                    hrun++;
                end else if (!scl_o && p_scl) begin
                    if (hrun != exp_hi) m_bad_hi++;
                    lrun = 1;
                    t_fall = cyc;
                end else begin
                    lrun++;
                end
                if (sda_o != p_sda) begin
                    if (scl_o && p_scl) begin
                        if (!sda_o) m_starts++; else m_stops++;
                    end else if (!scl_o) begin
                        if (cyc - t_fall != exp_dly) m_bad_lag++;
                    end else begin
                        m_bad_lag++;
                    end
                end
            end
            if (done_o) begin
                m_ndone++;
                if (busy_o || !p_busy) m_bad_done++;
            end
            p_scl = scl_o; p_sda = sda_o; p_busy = busy_o;
        end
    end

    // watchdog
    always @(negedge clk) begin
        if (cyc == 150000) begin
            n_total++; n_fail++;
            $display("FAIL R9 watchdog actual=hung expected=frame end");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    function automatic int eff_per(input int p);
        if (p == 0) return 32;
        if (p < 4) return 4;
        return p;
    endfunction

    function automatic logic exp_bit(input int k);
        int slot = k / 9;
        int pos  = k % 9;
        logic [7:0] b;
        if (k == 9 * (exp_n + 1)) return 1'b0;
        if (pos == 8) return 1'b1;
        b = (slot == 0) ? {exp_addr, exp_dir} : buf_byte(exp_seed, slot - 1);
        return b[7 - pos];
    endfunction

    int done_base;

    task automatic launch(input int p, input int d, input logic [6:0] a,
                          input logic dr, input int n, input logic [7:0] s);
        exp_p = eff_per(p);
        exp_hi = exp_p / 2;
        exp_lo = exp_p - exp_hi;
        exp_dly = (d >= exp_lo) ? exp_lo - 1 : d;
        exp_n = n; exp_addr = a; exp_dir = dr; exp_seed = s;
        done_base = m_ndone;
        @(posedge clk); #2;
        period_i = p[7:0]; delay_i = d[7:0]; addr_i = a; dir_i = dr;
        nbytes_i = n[3:0]; seed_r = s; start_i = 1'b1;
        @(posedge clk); #2;
        start_i = 1'b0;
    endtask

    task automatic finish_frame();
        int mis_data = 0;
        int mis_ninth = 0;
        while (m_ndone == done_base) @(negedge clk);
        check("R2 start condition count", m_starts, 1);
        check("R8 stop condition count", m_stops, 1);
        check("R5 low phase length errors", m_bad_lo, 0);
        check("R5 high phase length errors", m_bad_hi, 0);
        check("R7 data lag errors", m_bad_lag, 0);
        check("R3 rising edge count", m_nrise, 9 * (exp_n + 1) + 1);
        for (int k = 0; k < m_nrise && k < 256; k++) begin
            if (m_bits[k] != exp_bit(k)) begin
                if (k % 9 == 8 && k != 9 * (exp_n + 1)) mis_ninth++; else mis_data++;
            end
        end
        check("R3 address/data bit errors", mis_data, 0);
        check("R4 ninth bit errors", mis_ninth, 0);
        check("R8 stop slot bit", int'(m_bits[9 * (exp_n + 1)]), 0);
        check("R9 busy length", m_blen, 2 * exp_hi + (9 * (exp_n + 1) + 1) * exp_p);
        check("R9 done placement errors", m_bad_done, 0);
        check("R9 done pulse count", m_ndone - done_base, 1);
    endtask

    // per, dly, addr, dir, nbytes, seed
    localparam logic [35:0] VEC [0:5] = '{
        {8'd32, 8'd3,  7'h5A, 1'b0, 4'd2, 8'hC3},
        {8'd10, 8'd0,  7'h01, 1'b1, 4'd1, 8'h00},
        {8'd7,  8'd2,  7'h7F, 1'b0, 4'd3, 8'hFF},
        {8'd0,  8'd5,  7'h33, 1'b0, 4'd1, 8'h5A},  // R6 default period
        {8'd2,  8'd9,  7'h40, 1'b1, 4'd1, 8'h81},  // R6 raised to 4, R7 delay clamp
        {8'd12, 8'd20, 7'h2C, 1'b0, 4'd0, 8'h00}   // R11 address-only frame
    };

    initial begin
        #35;
        check("R1 reset scl", int'(scl_o), 1);
        check("R1 reset sda", int'(sda_o), 1);
        check("R1 reset busy", int'(busy_o), 0);
        check("R1 reset done", int'(done_o), 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);

        foreach (VEC[i]) begin
            launch(int'(VEC[i][35:28]), int'(VEC[i][27:20]), VEC[i][19:13],
                   VEC[i][12], int'(VEC[i][11:8]), VEC[i][7:0]);
            finish_frame();
            repeat (5) @(posedge clk);
        end

        // R10: second start and changed inputs mid-frame have no effect
        launch(16, 2, 7'h15, 1'b0, 2, 8'h77);
        repeat (40) @(posedge clk);
        #2;
        period_i = 8'd6; delay_i = 8'd0; addr_i = 7'h6A; dir_i = 1'b1; nbytes_i = 4'd5;
        start_i = 1'b1;
        @(posedge clk); #2;
        start_i = 1'b0;
        finish_frame();
        repeat (30) @(negedge clk);
        check("R10 no second frame busy", int'(busy_o), 0);
        check("R10 no extra done", m_ndone - done_base, 1);
        @(negedge clk);
        check("R1 idle scl after frame", int'(scl_o), 1);
        check("R1 idle sda after frame", int'(sda_o), 1);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule